// File: doc/BRIEF.md
# Synchronous Three-Wire Serial Shift Port

This block moves one byte at a time over three wires: a serial data output, a serial data input and a shift clock. In master mode it drives the shift clock itself. The clock comes from a divider of the system clock, which here is the instruction-cycle clock. In slave mode it follows a shift clock supplied from outside. The external clock and serial input first pass through two-stage synchronizers, and their edges are then found in the system clock domain.

Software controls the port through four 8-bit registers on a simple write/read bus. It loads the byte to send, sets the transfer flag, waits for the flag to drop, and then reads the received byte from the same register. Writing zero to the transfer flag aborts the exchange after fewer than eight bits. A sticky completion flag, gated by an enable bit, forms the interrupt request.

Data goes out most significant bit first. The data output changes when the shift clock falls, and the input is sampled when it rises. The shift clock rests low.

Top module: `ssp_port`

## Requirements
- R1: The control register sits at address 0: bit 0 enables the port, bits 2:1 select the rate, bit 3 selects master (1) or slave (0), and bit 4 enables the interrupt. While bit 0 is 0, `so_oe` and `sk_oe` are low and a start request is ignored, so the busy register (address 1, bit 0) reads 0.
- R2: In master mode the SK period is 2 clock cycles for rate 00, 4 cycles for rate 01, and 8 cycles for rates 10 and 11, with equal high and low halves.
- R3: Writing 1 to bit 0 at address 1 while enabled and idle starts a transfer. In master mode exactly eight SK pulses follow, after which the busy bit clears by itself.
- R4: Writing 0 to bit 0 at address 1 during a transfer ends it at once. SK stays low afterwards and the completion flag is not set.
- R5: The completion flag (address 3, bit 0) is set when the eighth bit has been shifted and holds until 1 is written to bit 0 at address 3. `irq_o` equals the flag ANDed with control bit 4.
- R6: The byte at address 2 leaves on `so_o` MSB first and changes only on SK falling edges. `si_i` is sampled on SK rising edges, and after completion address 2 reads back the eight received bits with the first one in the MSB.
- R7: SK is low whenever no transfer is running. `sk_oe` is high only when the port is enabled in master mode.
- R8: A write to address 2 is accepted only while SK is low. While SK is high the write is ignored and the register keeps its contents.
- R9: In slave mode the port shifts on the synchronized external `sk_i`. The busy bit stays set through seven external pulses and clears after the falling edge of the eighth.
- R10: In slave mode, a start requested while `sk_i` is high waits until SK is seen low. The pulse that was already in progress is not counted as a bit.

States: IDLE (no transfer), ARM (slave start waiting for SK low), LOW (SK low phase), HIGH (SK high phase). The transitions are:
- IDLE→LOW on start (master, or slave with SK low).
- IDLE→ARM on a slave start with SK high.
- ARM→LOW when SK is seen low.
- LOW→HIGH on a divider tick or a synchronized rising edge.
- HIGH→LOW on a tick or falling edge before the eighth bit.
- HIGH→IDLE on the eighth bit.
- Any state→IDLE on abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction-cycle) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sk_i | input | 1 | External shift clock (slave mode) |
| si_i | input | 1 | Serial data input |
| sk_o | output | 1 | Generated shift clock (master mode) |
| sk_oe | output | 1 | Drive enable for `sk_o` |
| so_o | output | 1 | Serial data output |
| so_oe | output | 1 | Drive enable for `so_o` |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The bench runs master transfers at every rate with random bytes. For each one it checks the pulse count, the spacing between pulses and the bit order on both wires. A wrong divider shows up as a period mismatch, and a bad count leaves the busy bit up or stops it early. An abort in mid-byte must leave SK silent and the flag clear; a design that finished the byte anyway would raise the flag. The slave cases cover a start while the external clock is high, where a design that counted the clipped pulse would receive a shifted byte. They also cover a data write during the high phase, which a design without the guard would let through and corrupt the byte to send.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_LOW,
        ST_HIGH
    } ssp_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_BUSY = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    localparam int C_EN     = 0;
    localparam int C_RATE   = 1;
    localparam int C_MASTER = 3;
    localparam int C_IEN    = 4;

    // Half of the SK period in clock cycles for a rate code.
    function automatic logic [2:0] half_cycles(input logic [1:0] rate);
        logic [2:0] h;
        if (rate[1])      h = 3'd4;
        else if (rate[0]) h = 3'd2;
        else              h = 3'd1;
        return h;
    endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == (half - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master,
    input  logic         start,
    input  logic         abort,
    input  logic         tick,
    input  logic         sk_s,
    input  logic         si_s,
    input  logic         si_raw,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         run_div,
    output logic         sk_drv,
    output logic         sk_level,
    output logic         so,
    output logic         done,
    output logic [W-1:0] sr_q
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    ssp_state_e    state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          cap_q;
    logic          sk_d_q;
    logic          rise, fall, adv_lo, adv_hi, last;

    assign rise   = sk_s & ~sk_d_q;
    assign fall   = ~sk_s & sk_d_q;
    assign adv_lo = master ? tick : rise;
    assign adv_hi = master ? tick : fall;
    assign last   = (bit_q == BW'(W - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (master || !sk_s) ? ST_LOW : ST_ARM;
            end
            ST_ARM: begin
                if (abort)      state_d = ST_IDLE;
                else if (!sk_s) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (abort)       state_d = ST_IDLE;
                else if (adv_lo) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (abort)       state_d = ST_IDLE;
                else if (adv_hi) state_d = last ? ST_IDLE : ST_LOW;
            end
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bit_q  <= '0;
            cap_q  <= 1'b0;
            sk_d_q <= 1'b0;
        end else begin
            sk_d_q <= sk_s;
            if (state_q == ST_IDLE || abort) bit_q <= '0;
            if (state_q == ST_LOW && !abort && adv_lo)
                cap_q <= master ? si_raw : si_s;
            if (state_q == ST_HIGH && !abort && adv_hi) begin
                sr_q  <= {sr_q[W-2:0], cap_q};
                bit_q <= last ? '0 : bit_q + BW'(1);
            end else if (load && !sk_level) begin
                sr_q <= load_val;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        run_div  = master && (state_q == ST_LOW || state_q == ST_HIGH);
        sk_drv   = master && (state_q == ST_HIGH);
        sk_level = master ? sk_drv : sk_s;
        so       = sr_q[W-1];
        done     = (state_q == ST_HIGH) && !abort && adv_hi && last;
    end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sk_i,
    input  logic              si_i,
    output logic              sk_o,
    output logic              sk_oe,
    output logic              so_o,
    output logic              so_oe,
    output logic              irq_o
);
    localparam int DIV_W = 3;

    logic [DATA_W-1:0] ctrl_q;
    logic              irq_flag_q;
    logic              ctrl_en, ctrl_master, ctrl_ien;
    logic [1:0]        ctrl_rate;
    logic              sk_s, si_s;
    logic              busy, run_div, tick, sk_drv, sk_level, so, done;
    logic              start, abort, load;
    logic [DATA_W-1:0] sr;

    assign ctrl_en     = ctrl_q[C_EN];
    assign ctrl_rate   = ctrl_q[C_RATE+1:C_RATE];
    assign ctrl_master = ctrl_q[C_MASTER];
    assign ctrl_ien    = ctrl_q[C_IEN];

    assign start = reg_wr && (reg_addr == A_BUSY) && reg_wdata[0] && ctrl_en && !busy;
    assign abort = busy && (!ctrl_en || (reg_wr && (reg_addr == A_BUSY) && !reg_wdata[0]));
    assign load  = reg_wr && (reg_addr == A_DATA);

    ssp_sync #(.STAGES(SYNC_STAGES)) u_sync_sk (
        .clk(clk), .rst_n(rst_n), .d(sk_i), .q(sk_s)
    );
    ssp_sync #(.STAGES(SYNC_STAGES)) u_sync_si (
        .clk(clk), .rst_n(rst_n), .d(si_i), .q(si_s)
    );

    ssp_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run_div),
        .half(half_cycles(ctrl_rate)), .tick(tick)
    );

    ssp_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .master(ctrl_master),
        .start(start), .abort(abort), .tick(tick),
        .sk_s(sk_s), .si_s(si_s), .si_raw(si_i),
        .load(load), .load_val(reg_wdata),
        .busy(busy), .run_div(run_div), .sk_drv(sk_drv),
        .sk_level(sk_level), .so(so), .done(done), .sr_q(sr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            irq_flag_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
            if (done)
                irq_flag_q <= 1'b1;
            else if (reg_wr && reg_addr == A_FLAG && reg_wdata[0])
                irq_flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL: reg_rdata = ctrl_q;
            A_BUSY: reg_rdata = {{(DATA_W-1){1'b0}}, busy};
            A_DATA: reg_rdata = sr;
            A_FLAG: reg_rdata = {{(DATA_W-1){1'b0}}, irq_flag_q};
        endcase
    end

    assign sk_o  = sk_drv;
    assign sk_oe = ctrl_en && ctrl_master;
    assign so_o  = ctrl_en && so;
    assign so_oe = ctrl_en;
    assign irq_o = irq_flag_q && ctrl_ien;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         master,
    input logic         busy,
    input logic         sk_o,
    input logic         sk_oe,
    input logic         so_oe,
    input logic         sk_level,
    input logic         irq_flag,
    input logic         load,
    input logic [W-1:0] sr
);
    a_r1_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!so_oe && !sk_oe));

    a_r7_sk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sk_o);

    a_r9_slave_no_sk_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master) |-> !sk_oe);

    a_r5_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));

    a_r8_load_blocked_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sk_level && load) |=> $stable(sr));
endmodule

bind ssp_port ssp_port_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .master(ctrl_master),
    .busy(busy), .sk_o(sk_o), .sk_oe(sk_oe), .so_oe(so_oe),
    .sk_level(sk_level), .irq_flag(irq_flag_q), .load(load), .sr(sr)
);

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sk_i, si_i, sk_o, sk_oe, so_o, so_oe, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // master-mode monitor state
    logic       mmon = 1'b0;
    logic [7:0] mon_rx = 8'd0;
    int         exp_per = 2;
    int         m_pulses, m_falls, m_perbad, m_last;
    logic       m_first, m_prev;
    logic [7:0] m_so;
    logic       m_si;

    // slave-mode drive
    logic s_sk = 1'b0;
    logic s_si = 1'b0;
    logic slave_drive = 1'b0;

    assign m_si = (m_falls < 8) ? mon_rx[7 - m_falls] : 1'b0;
    assign sk_i = s_sk;
    assign si_i = slave_drive ? s_si : m_si;

    ssp_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sk_i(sk_i),
        .si_i(si_i), .sk_o(sk_o), .sk_oe(sk_oe), .so_o(so_o),
        .so_oe(so_oe), .irq_o(irq_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!mmon) begin
            m_pulses = 0; m_falls = 0; m_perbad = 0; m_first = 1'b1;
            m_so = 8'd0; m_last = 0; m_prev = sk_o;
        end else begin
            if (sk_o && !m_prev) begin
                m_so = {m_so[6:0], so_o};
                m_pulses++;
                if (!m_first && (cyc - m_last) != exp_per) m_perbad++;
                m_last = cyc;
                m_first = 1'b0;
            end
            if (!sk_o && m_prev) m_falls++;
            m_prev = sk_o;
        end
    end

    function automatic int half_of(input logic [1:0] rate);
        return rate[1] ? 4 : (rate[0] ? 2 : 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output int waited);
        logic [7:0] b;
        waited = 0;
        rd(2'd1, b);
        while (b[0] && waited < 400) begin
            rd(2'd1, b);
            waited++;
        end
    endtask

    task automatic master_xfer(input logic [1:0] rate, input logic [7:0] tx,
                               input logic [7:0] rx, input logic ien);
        logic [7:0] d;
        int w;
        slave_drive = 1'b0;
        mmon = 1'b0;
        wr(2'd0, {3'b000, ien, 1'b1, rate, 1'b1});
        wr(2'd2, tx);
        wr(2'd3, 8'h01);
        mon_rx = rx;
        exp_per = 2 * half_of(rate);
        @(negedge clk);
        mmon = 1'b1;
        wr(2'd1, 8'h01);
        wait_idle(w);
        @(negedge clk);
        chk("R3 eight SK pulses", m_pulses, 8);
        chk("R2 SK period", m_perbad, 0);
        chk("R6 SO bit order MSB first", m_so, tx);
        chk("R7 SK low after transfer", sk_o, 1'b0);
        rd(2'd2, d);
        chk("R6 received byte", d, rx);
        rd(2'd3, d);
        chk("R5 completion flag set", d, 8'h01);
        chk("R5 irq gated by enable", irq_o, ien);
        mmon = 1'b0;
    endtask

    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rx, input logic arm_high);
        logic [7:0] d, got;
        slave_drive = 1'b1;
        s_sk = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd2, tx);
        wr(2'd3, 8'h01);
        if (arm_high) begin
            s_sk = 1'b1;
            repeat (5) @(negedge clk);
            wr(2'd1, 8'h01);
            repeat (6) @(negedge clk);
            s_sk = 1'b0;
            repeat (6) @(negedge clk);
        end else begin
            wr(2'd1, 8'h01);
        end
        got = 8'd0;
        for (int i = 7; i >= 0; i--) begin
            s_si = rx[i];
            repeat (5) @(negedge clk);
            got = {got[6:0], so_o};
            if (i == 0) begin
                rd(2'd1, d);
                chk("R9 busy held through seven pulses", d, 8'h01);
            end
            s_sk = 1'b1;
            repeat (5) @(negedge clk);
            s_sk = 1'b0;
        end
        repeat (6) @(negedge clk);
        rd(2'd1, d);
        chk(arm_high ? "R10 busy clear after eight pulses" : "R9 busy clear after eighth pulse", d, 8'h00);
        rd(2'd2, d);
        chk(arm_high ? "R10 received byte, clipped pulse not counted" : "R9 received byte", d, rx);
        chk("R9 SO bits in slave mode", got, tx);
        rd(2'd3, d);
        chk("R5 flag after slave transfer", d, 8'h01);
        slave_drive = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [7:0] d;
        int highs;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
        rd(2'd1, d); chk("R1 busy reset", d, 8'h00);
        rd(2'd3, d); chk("R5 flag reset", d, 8'h00);
        chk("R1 outputs not driven at reset", {so_oe, sk_oe, irq_o}, 3'b000);

        // disabled: start ignored
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R1 start ignored while disabled", d, 8'h00);
        chk("R1 so_oe/sk_oe low while disabled", {so_oe, sk_oe}, 2'b00);

        // directed master, every rate
        master_xfer(2'b00, 8'hA5, 8'h3C, 1'b1);
        master_xfer(2'b01, 8'h01, 8'h80, 1'b0);
        master_xfer(2'b10, 8'hFF, 8'h00, 1'b1);
        master_xfer(2'b11, 8'h00, 8'hFF, 1'b1);
        chk("R7 sk_oe in master mode", sk_oe, 1'b1);

        // flag clear by write-1
        wr(2'd3, 8'h01);
        rd(2'd3, d); chk("R5 flag cleared by write", d, 8'h00);
        chk("R5 irq low after clear", irq_o, 1'b0);

        // random master transfers
        for (int k = 0; k < 10; k++) begin
            master_xfer(2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end

        // abort in mid-transfer
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h0D);
        wr(2'd2, 8'hC3);
        wr(2'd1, 8'h01);
        repeat (20) @(negedge clk);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R4 busy cleared by abort", d, 8'h00);
        highs = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (sk_o) highs++;
        end
        chk("R4 SK silent after abort", highs, 0);
        rd(2'd3, d); chk("R4 no flag on abort", d, 8'h00);
        chk("R4 no irq on abort", irq_o, 1'b0);

        // slave mode
        slave_xfer(8'h96, 8'h5B, 1'b0);
        chk("R7 sk_oe low in slave mode", sk_oe, 1'b0);
        slave_xfer(8'h2E, 8'hD1, 1'b1);

        // data load blocked while SK high
        slave_drive = 1'b1;
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h3C);
        s_sk = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'hA5);
        s_sk = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd2, d); chk("R8 load ignored while SK high", d, 8'h3C);
        wr(2'd2, 8'h5A);
        rd(2'd2, d); chk("R8 load accepted while SK low", d, 8'h5A);

        summary();
    end
endmodule